// File: doc/BRIEF.md
# Dual-Compare Output Timer

A 16-bit timer that counts upward on a selectable count-enable strobe and compares its value against two compare channels. Each match raises a one-cycle interrupt pulse and can change the level of a single generated waveform. The waveform is then optionally inverted per pin group and gated onto six output pins. A third interrupt pulse marks counter overflow.

Software starts and stops the timer with one run bit. Stopping clears the counter and returns the waveform to its idle low level. The count cannot be written. It and both active compare values are always visible on read ports. Compare writes go through a staging register per channel. While stopped, a write takes effect at once. While running, the staged value moves to the active register only at a defined event. In free-run mode that event is overflow. In clear mode, where a compare-1 match returns the count to zero, the event is that compare-1 match.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `run` is 1, `count_q` advances by one on every clock edge where the strobe `tick_src[src_sel]` is 1. Strobes on the other `tick_src` lines leave the count unchanged.
- R2: When `run` is 0, `count_q` is 0 and the waveform level is 0 after the next clock edge.
- R3: Each interrupt is a one-cycle pulse in the cycle after a selected strobe edge. `irq_cmp0` fires when the count equalled the active compare-0 value at that edge, `irq_cmp1` likewise for compare 1, and `irq_ovf` fires when the count was FFFFh and no clear happened. A count stalled on a matching value with no strobe raises no further pulse.
- R4: A compare write (`cmp_wr[k]`=1) while `run` is 0 appears on the active read port after the next clock edge.
- R5: In free-run mode (`clear_mode`=0), a write while running leaves the active value unchanged until the strobe edge at which the count wraps from FFFFh to 0000h. The staged value becomes active at that edge.
- R6: In clear mode (`clear_mode`=1), a strobe edge with a compare-1 match returns the count to 0000h, and the staged compare values become active at that same edge.
- R7: On a match, the 2-bit action code (`act0` for compare 0, `act1` for compare 1) sets the waveform as follows: 00 keeps the level, 01 drives it low, 10 drives it high, and 11 toggles it.
- R8: When both channels match at the same strobe edge, only the compare-1 action is applied.
- R9: `inv[0]` inverts the waveform for pins 0 to 2 and `inv[1]` for pins 3 to 5.
- R10: For pin i, the output is as follows. If `out_en[i]`=0, it follows `port_data[i]`. If `out_en[i]`=1 and `port_data[i]`=0, it drives a fixed 0. Otherwise it drives the (possibly inverted) waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 counts, 0 stops and clears |
| src_sel | input | 2 | Selects which strobe line advances the count |
| tick_src | input | 4 | Count-enable strobes, one per count source |
| clear_mode | input | 1 | 1 clears the count on a compare-1 match |
| act0 | input | 2 | Waveform action on a compare-0 match |
| act1 | input | 2 | Waveform action on a compare-1 match |
| inv | input | 2 | Inversion per pin group |
| out_en | input | 6 | Waveform enable per pin |
| port_data | input | 6 | Port data per pin |
| cmp_wr | input | 2 | Write strobe per compare channel |
| cmp_wdata | input | 16 | Compare write data |
| count_q | output | 16 | Live count |
| cmp0_q | output | 16 | Active compare-0 value |
| cmp1_q | output | 16 | Active compare-1 value |
| irq_cmp0 | output | 1 | Compare-0 match pulse |
| irq_cmp1 | output | 1 | Compare-1 match pulse |
| irq_ovf | output | 1 | Overflow pulse |
| pin_out | output | 6 | Shaped output pins |

## Verification
The assertions assume that the control inputs (`clear_mode`, the action codes and `src_sel`) are held steady across a strobe edge. They also assume that `run` is the only means of forcing the count back to zero outside clear mode. The stimulus changes configuration only while the timer is stopped or while no strobe is applied. Strobes are driven at the falling clock edge. Compare writes are issued only in cycles without a strobe, so a write never coincides with a staged-value transfer.

// File: rtl/dct_pkg.sv
package dct_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_e;

  // Waveform level after a match action is applied.
  function automatic logic apply_act(input logic [1:0] code, input logic cur);
    case (act_e'(code))
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  // Level driven on one pin from enable, port data and waveform.
  function automatic logic pin_drive(input logic en, input logic pd, input logic lvl);
    if (!en) return pd;
    return pd & lvl;
  endfunction

endpackage

// File: rtl/dct_tick_sel.sv
module dct_tick_sel #(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] tick_src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  assign tick = tick_src[sel];
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         clear_mode,
  input  logic         match1,
  output logic [W-1:0] count,
  output logic         ovf_evt,
  output logic         clr_evt
);
  localparam logic [W-1:0] ALL_ONES = '1;

  logic strobe;
  assign strobe  = run & tick;
  assign clr_evt = strobe & clear_mode & match1;
  assign ovf_evt = strobe & (count == ALL_ONES) & ~clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (!run)    count <= '0;
    else if (clr_evt) count <= '0;
    else if (strobe)  count <= count + 1'b1;
  end

  // R2
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !(clear_mode && match1)) |=> count == $past(count) + 1'b1);

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(count));

  // R6
  clear_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && clear_mode && match1) |=> count == '0);
endmodule

// File: rtl/dct_cmp_chan.sv
module dct_cmp_chan #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  input  logic [W-1:0] count,
  output logic [W-1:0] active,
  output logic         match
);
  logic [W-1:0] staged;

  assign match = (count == active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  staged <= '0;
    else if (wr) staged <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             active <= '0;
    else if (!run && wr)    active <= wdata;
    else if (run && load)   active <= staged;
  end

  // R4
  stopped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && wr) |=> active == $past(wdata));

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> $stable(active));
endmodule

// File: rtl/dct_wave.sv
module dct_wave #(
  parameter int unsigned N_PIN = 6,
  parameter int unsigned N_GRP = 2,
  localparam int unsigned PER_GRP = N_PIN / N_GRP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             strobe,
  input  logic             match0,
  input  logic             match1,
  input  logic [1:0]       act0,
  input  logic [1:0]       act1,
  input  logic [N_GRP-1:0] inv,
  input  logic [N_PIN-1:0] out_en,
  input  logic [N_PIN-1:0] port_data,
  output logic             wave,
  output logic [N_PIN-1:0] pin_out
);
  import dct_pkg::*;

  logic hit0, hit1;
  assign hit1 = strobe & match1;
  assign hit0 = strobe & match0 & ~match1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wave <= 1'b0;
    else if (!run)  wave <= 1'b0;
    else if (hit1)  wave <= apply_act(act1, wave);
    else if (hit0)  wave <= apply_act(act0, wave);
  end

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    logic lvl;
    assign lvl        = wave ^ inv[i / PER_GRP];
    assign pin_out[i] = pin_drive(out_en[i], port_data[i], lvl);
  end

  // R7
  toggle_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && match0 && !match1 && act0 == ACT_TOGGLE) |=> wave != $past(wave));

  // R7
  no_match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !(strobe && (match0 || match1))) |=> $stable(wave));

  // R8
  cmp1_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && match0 && match1 && act1 == ACT_LOW) |=> !wave);
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_SRC = 4,
  parameter int unsigned N_PIN = 6,
  parameter int unsigned N_GRP = 2,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] src_sel,
  input  logic [N_SRC-1:0] tick_src,
  input  logic             clear_mode,
  input  logic [1:0]       act0,
  input  logic [1:0]       act1,
  input  logic [N_GRP-1:0] inv,
  input  logic [N_PIN-1:0] out_en,
  input  logic [N_PIN-1:0] port_data,
  input  logic [1:0]       cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] cmp0_q,
  output logic [CNT_W-1:0] cmp1_q,
  output logic             irq_cmp0,
  output logic             irq_cmp1,
  output logic             irq_ovf,
  output logic [N_PIN-1:0] pin_out
);
  logic tick, strobe, ovf_evt, clr_evt, xfer_evt;
  logic match0, match1, wave;

  dct_tick_sel #(.N_SRC(N_SRC)) u_sel (
    .tick_src(tick_src), .sel(src_sel), .tick(tick)
  );

  assign strobe = run & tick;

  dct_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .clear_mode(clear_mode), .match1(match1),
    .count(count_q), .ovf_evt(ovf_evt), .clr_evt(clr_evt)
  );

  // Staged compare values move at overflow (free-run) or compare-1 clear.
  assign xfer_evt = clear_mode ? clr_evt : ovf_evt;

  dct_cmp_chan #(.W(CNT_W)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .run(run), .wr(cmp_wr[0]), .wdata(cmp_wdata),
    .load(xfer_evt), .count(count_q), .active(cmp0_q), .match(match0)
  );

  dct_cmp_chan #(.W(CNT_W)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .run(run), .wr(cmp_wr[1]), .wdata(cmp_wdata),
    .load(xfer_evt), .count(count_q), .active(cmp1_q), .match(match1)
  );

  dct_wave #(.N_PIN(N_PIN), .N_GRP(N_GRP)) u_wave (
    .clk(clk), .rst_n(rst_n), .run(run), .strobe(strobe),
    .match0(match0), .match1(match1), .act0(act0), .act1(act1),
    .inv(inv), .out_en(out_en), .port_data(port_data),
    .wave(wave), .pin_out(pin_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_cmp0 <= 1'b0;
      irq_cmp1 <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      irq_cmp0 <= strobe & match0;
      irq_cmp1 <= strobe & match1;
      irq_ovf  <= ovf_evt;
    end
  end

  // R3
  irq0_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp0 |-> $past(run && tick));

  // R3
  irq_ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> (count_q == '0 && $past(run && tick)));

  // R5
  ovf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear_mode && ovf_evt && !cmp_wr[0]) |=> cmp0_q == $past(u_ch0.staged));
endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, clear_mode = 1'b0;
  logic [1:0] src_sel = '0, act0 = '0, act1 = '0, inv = '0, cmp_wr = '0;
  logic [3:0] tick_src = '0;
  logic [5:0] out_en = '0, port_data = '0, pin_out;
  logic [15:0] cmp_wdata = '0, count_q, cmp0_q, cmp1_q;
  logic irq_cmp0, irq_cmp1, irq_ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dual_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .src_sel(src_sel), .tick_src(tick_src),
    .clear_mode(clear_mode), .act0(act0), .act1(act1), .inv(inv),
    .out_en(out_en), .port_data(port_data), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .count_q(count_q), .cmp0_q(cmp0_q), .cmp1_q(cmp1_q),
    .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1), .irq_ovf(irq_ovf), .pin_out(pin_out)
  );

  typedef struct packed {
    logic       clr;
    logic       inv0;
    logic [1:0] a0;
    logic [1:0] a1;
    logic [7:0] n;
    logic [15:0] cnt;
    logic       lvl;
  } vec_t;

  // compare 0 = 3, compare 1 = 7; lvl is pin 0 after n strobes
  localparam vec_t TBL [9] = '{
    '{1'b0, 1'b0, 2'b10, 2'b01, 8'd5,  16'd5, 1'b1},
    '{1'b0, 1'b0, 2'b10, 2'b01, 8'd9,  16'd9, 1'b0},
    '{1'b0, 1'b0, 2'b11, 2'b00, 8'd9,  16'd9, 1'b1},
    '{1'b0, 1'b0, 2'b00, 2'b11, 8'd9,  16'd9, 1'b1},
    '{1'b0, 1'b0, 2'b11, 2'b11, 8'd9,  16'd9, 1'b0},
    '{1'b0, 1'b0, 2'b01, 2'b10, 8'd3,  16'd3, 1'b0},
    '{1'b1, 1'b0, 2'b11, 2'b11, 8'd8,  16'd0, 1'b0},
    '{1'b1, 1'b0, 2'b11, 2'b11, 8'd12, 16'd4, 1'b1},
    '{1'b0, 1'b1, 2'b10, 2'b01, 8'd5,  16'd5, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_src = 4'b1111;
    end
    @(negedge clk) tick_src = 4'b0000;
  endtask

  task automatic write_cmp(input int ch, input logic [15:0] v);
    @(negedge clk) begin cmp_wr = 2'b01 << ch; cmp_wdata = v; end
    @(negedge clk) cmp_wr = 2'b00;
  endtask

  task automatic halt();
    @(negedge clk) run = 1'b0;
    @(negedge clk);
  endtask

  task automatic go();
    @(negedge clk) run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    port_data = 6'b101010;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state; R10 pins follow port data with enables off
    check("R2 reset count", count_q, 0);
    check("R3 reset irqs", {irq_cmp0, irq_cmp1, irq_ovf}, 0);
    check("R10 disabled pins", pin_out, 6'b101010);

    // table walk: R7 actions, R6 clear, R9 inversion
    out_en = 6'b111111; port_data = 6'b111111;
    for (int k = 0; k < 9; k++) begin
      halt();
      clear_mode = TBL[k].clr; inv = {1'b0, TBL[k].inv0};
      act0 = TBL[k].a0; act1 = TBL[k].a1;
      write_cmp(0, 16'd3);
      write_cmp(1, 16'd7);
      go();
      ticks(int'(TBL[k].n));
      check($sformatf("R7 R6 vec%0d count", k), count_q, TBL[k].cnt);
      check($sformatf("R7 R9 vec%0d pin0", k), pin_out[0], TBL[k].lvl);
      check($sformatf("R9 vec%0d pin3", k), pin_out[3], TBL[k].lvl ^ TBL[k].inv0);
    end

    // R4 stopped write immediate
    halt();
    clear_mode = 1'b0; inv = 2'b00; act0 = 2'b00; act1 = 2'b00;
    write_cmp(0, 16'd5);
    check("R4 stopped write", cmp0_q, 16'd5);
    write_cmp(1, 16'hFFF0);

    // R1 source select
    src_sel = 2'd2;
    go();
    for (int i = 0; i < 3; i++) @(negedge clk) tick_src = 4'b0001;
    @(negedge clk) tick_src = 4'b0000;
    check("R1 unselected strobe", count_q, 0);
    for (int i = 0; i < 3; i++) @(negedge clk) tick_src = 4'b0100;
    @(negedge clk) tick_src = 4'b0000;
    check("R1 selected strobe", count_q, 3);

    // R3 pulses and no repeat on a stalled match
    ticks(2);
    check("R3 count at match", count_q, 5);
    repeat (3) @(negedge clk);
    check("R3 stalled no irq", irq_cmp0, 1'b0);
    ticks(1);
    check("R3 irq_cmp0 pulse", irq_cmp0, 1'b1);
    @(negedge clk);
    check("R3 irq_cmp0 one cycle", irq_cmp0, 1'b0);

    // R5 free-run staging until overflow
    write_cmp(0, 16'd9);
    check("R5 held while running", cmp0_q, 16'd5);
    ticks(65529);
    check("R5 at FFFF", count_q, 16'hFFFF);
    check("R5 still held", cmp0_q, 16'd5);
    check("R3 no early ovf", irq_ovf, 1'b0);
    ticks(1);
    check("R3 irq_ovf", irq_ovf, 1'b1);
    check("R5 wrap count", count_q, 16'd0);
    check("R5 loaded at overflow", cmp0_q, 16'd9);

    // R6 clear mode staging
    halt();
    clear_mode = 1'b1;
    write_cmp(1, 16'd4);
    go();
    ticks(2);
    write_cmp(1, 16'd6);
    check("R6 held while running", cmp1_q, 16'd4);
    ticks(2);
    check("R6 count before match", count_q, 16'd4);
    check("R6 still held", cmp1_q, 16'd4);
    ticks(1);
    check("R6 cleared", count_q, 16'd0);
    check("R6 loaded at match", cmp1_q, 16'd6);
    check("R3 irq_cmp1", irq_cmp1, 1'b1);

    // R8 compare-1 priority
    halt();
    clear_mode = 1'b0; src_sel = 2'd0;
    write_cmp(0, 16'd2);
    write_cmp(1, 16'd2);
    act0 = 2'b10; act1 = 2'b01;
    go();
    ticks(3);
    check("R8 cmp1 low wins", pin_out[0], 1'b0);
    halt();
    act0 = 2'b01; act1 = 2'b10;
    go();
    ticks(3);
    check("R8 cmp1 high wins", pin_out[0], 1'b1);

    // R10 fixed level when port data is 0
    port_data = 6'b111110;
    #1;
    check("R10 fixed low pin0", pin_out[0], 1'b0);
    check("R10 waveform pin1", pin_out[1], 1'b1);

    // R2 stop clears count and level
    halt();
    check("R2 stop count", count_q, 16'd0);
    check("R2 stop level", pin_out[1], 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule